// File: doc/BRIEF.md
# Interrupt Cause and Mask Aggregator

This block gathers interrupt events for a system controller and presents them to a CPU through a small set of 32-bit registers. Peripherals pulse event-set lines that latch bits into a main cause register; software reads the cause, clears the bits it has served by writing zeros (a write is ANDed into the register), and chooses which causes reach the CPU through a mask register. A single registered interrupt line is raised whenever any unmasked cause bit is pending.

Two further read-only registers summarise the per-port Ethernet interrupt flags. They hold no state: each read reflects the live flags. The host bus is big-endian while the registers are little-endian, so every word crossing the bus is byte-reversed in both directions.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the interrupt output is 0, and reads of the cause (offset 0xC18) and mask (offset 0xC1C) registers return 0.
- R2: A write to offset 0xC1C replaces the mask with the byte-reversed bus word; reading it back returns the bus word that was written.
- R3: A write to offset 0xC18 ANDs the byte-reversed bus word into the cause register: a 0 clears the bit, a 1 keeps it, no bit is ever set by a write.
- R4: A high level on event_set[i] at a clock edge sets cause register bit i; when that edge also carries a cause write that would clear bit i, the bit ends up set.
- R5: irq_out is the OR of all bits of (cause AND mask), registered: it changes one clock edge after the cause or mask changes.
- R6: A read of offset 0xC98 returns, in register bit p, the current eth_sum[p] for each port p (bits 0 and 1, all others 0); writes to it change no register.
- R7: A read of offset 0x103A00 returns the same per-port summary, eth_sum[p] in register bit p, computed at the read.
- R8: Read data is byte-reversed: register byte k (bits 8k+7..8k) appears in bus byte 3-k, so register bit 0 is bus bit 24.
- R9: Reads of any other offset return 0, and writes to any other offset change no register.
- R10: For each read request (bus_req high, bus_we low) bus_rvalid is high with the data exactly one clock edge later, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 24 | Register byte offset |
| bus_wdata | input | 32 | Write data, host byte order |
| bus_rdata | output | 32 | Read data, host byte order, registered |
| bus_rvalid | output | 1 | Read data valid |
| event_set | input | 32 | Per-bit cause set pulses, register bit order |
| eth_sum | input | 2 | Per-port Ethernet interrupt summary flags |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A corrupted cause or mask bit shows on irq_out one edge after it appears, and in the word returned by the next read of that register, one edge after the request. A wrong byte lane in the swap path misplaces a field in every read, so a single event bit set in register byte 0 exposes it in host byte 3. A lost set-versus-clear priority only shows when an event and a clearing write meet on the same edge, so that collision is driven directly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 24;
  localparam int BYTES = DATA_W / 8;

  parameter logic [ADDR_W-1:0] OFF_CAUSE   = 24'h000C18;
  parameter logic [ADDR_W-1:0] OFF_MASK    = 24'h000C1C;
  parameter logic [ADDR_W-1:0] OFF_HICAUSE = 24'h000C98;
  parameter logic [ADDR_W-1:0] OFF_SERIAL  = 24'h103A00;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_CAUSE   = 3'd1,
    SEL_MASK    = 3'd2,
    SEL_HICAUSE = 3'd3,
    SEL_SERIAL  = 3'd4
  } reg_sel_e;

  // Reverse the byte lanes of a word (host order <-> register order).
  function automatic logic [DATA_W-1:0] lane_flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int k = 0; k < BYTES; k++) begin
      r[8*(BYTES-1-k) +: 8] = v[8*k +: 8];
    end
    return r;
  endfunction

  // Any unmasked pending cause.
  function automatic logic pending_any(input logic [DATA_W-1:0] c,
                                       input logic [DATA_W-1:0] m);
    return |(c & m);
  endfunction
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    unique case (addr)
      OFF_CAUSE:   sel = SEL_CAUSE;
      OFF_MASK:    sel = SEL_MASK;
      OFF_HICAUSE: sel = SEL_HICAUSE;
      OFF_SERIAL:  sel = SEL_SERIAL;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cause_wr,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wr_val,
  input  logic [DATA_W-1:0] event_set,
  output logic [DATA_W-1:0] cause_q,
  output logic [DATA_W-1:0] mask_q
);
  logic [DATA_W-1:0] cause_kept;
  logic [DATA_W-1:0] cause_d;

  // Clearing write first, then peripheral sets on top: set wins.
  always_comb begin
    cause_kept = cause_wr ? (cause_q & wr_val) : cause_q;
    cause_d    = cause_kept | event_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      cause_q <= cause_d;
      if (mask_wr) mask_q <= wr_val;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int HI_BASE   = 0,
  parameter int SER_BASE  = 0
) (
  input  logic [NUM_PORTS-1:0] eth_sum,
  output logic [DATA_W-1:0]    hi_word,
  output logic [DATA_W-1:0]    ser_word
);
  logic [DATA_W-1:0] hi_bits;
  logic [DATA_W-1:0] ser_bits;

  for (genvar p = 0; p < DATA_W; p++) begin : g_bit
    if (p >= HI_BASE && p < HI_BASE + NUM_PORTS) begin : g_hi
      assign hi_bits[p] = eth_sum[p-HI_BASE];
    end else begin : g_hi0
      assign hi_bits[p] = 1'b0;
    end
    if (p >= SER_BASE && p < SER_BASE + NUM_PORTS) begin : g_ser
      assign ser_bits[p] = eth_sum[p-SER_BASE];
    end else begin : g_ser0
      assign ser_bits[p] = 1'b0;
    end
  end

  assign hi_word  = hi_bits;
  assign ser_word = ser_bits;
endmodule

// File: rtl/irq_line.sv
module irq_line
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cause_q,
  input  logic [DATA_W-1:0] mask_q,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_any(cause_q, mask_q);
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [23:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [31:0]       event_set,
  input  logic [NUM_PORTS-1:0] eth_sum,
  output logic              irq_out
);
  reg_sel_e          sel;
  logic              cause_wr;
  logic              mask_wr;
  logic              rd_req;
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] cause_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] ser_word;
  logic [DATA_W-1:0] rd_word;

  irq_addr_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign rd_req   = bus_req & ~bus_we;
  assign cause_wr = bus_req & bus_we & (sel == SEL_CAUSE);
  assign mask_wr  = bus_req & bus_we & (sel == SEL_MASK);
  assign wr_val   = lane_flip(bus_wdata);

  irq_cause_mask u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cause_wr  (cause_wr),
    .mask_wr   (mask_wr),
    .wr_val    (wr_val),
    .event_set (event_set),
    .cause_q   (cause_q),
    .mask_q    (mask_q)
  );

  irq_summary #(.NUM_PORTS(NUM_PORTS)) u_sum (
    .eth_sum  (eth_sum),
    .hi_word  (hi_word),
    .ser_word (ser_word)
  );

  irq_line u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .irq_q   (irq_out)
  );

  always_comb begin
    unique case (sel)
      SEL_CAUSE:   rd_word = cause_q;
      SEL_MASK:    rd_word = mask_q;
      SEL_HICAUSE: rd_word = hi_word;
      SEL_SERIAL:  rd_word = ser_word;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= lane_flip(rd_word);
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [31:0]       event_set,
  input logic              irq_out,
  input logic              mask_wr,
  input logic              cause_wr,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] mask_q
);
  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> (!irq_out && cause_q == '0 && mask_q == '0));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> mask_q == lane_flip($past(bus_wdata)));

  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cause_q & ~$past(cause_q) & ~$past(event_set)) == '0);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_set != '0) |=> (cause_q & $past(event_set)) == $past(event_set));

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == |($past(cause_q) & $past(mask_q)));

  p_rvalid_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .event_set  (event_set),
  .irq_out    (irq_out),
  .mask_wr    (mask_wr),
  .cause_wr   (cause_wr),
  .cause_q    (cause_q),
  .mask_q     (mask_q)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] event_set = '0;
  logic [1:0]  eth_sum = '0;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .event_set(event_set), .eth_sum(eth_sum),
    .irq_out(irq_out)
  );

  function automatic logic [31:0] flip(input logic [31:0] v);
    return {<<8{v}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Monitor: pop expected read data as results appear.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R10 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic access(input logic we, input logic [23:0] a, input logic [31:0] d,
                        input logic [31:0] ev);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; event_set = ev;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; event_set = '0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    access(1'b0, a, 32'h0, 32'h0);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    access(1'b1, a, d, 32'h0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(24'h000C18, 32'h0, "R1 cause after reset");
    rd(24'h000C1C, 32'h0, "R1 mask after reset");

    // Mask covers register byte 3 (host byte 0).
    wr(24'h000C1C, 32'h0000_00FF);
    rd(24'h000C1C, 32'h0000_00FF, "R2 mask readback");

    // Event on register bit 24: host sees bit 0.
    access(1'b0, 24'h000000, 32'h0, 32'h0100_0000);
    exp_q.push_back(32'h0); tag_q.push_back("R9 unknown read");
    check("R5 irq not yet", {31'b0, irq_out}, 32'h0);
    idle(1);
    check("R5 irq raised", {31'b0, irq_out}, 32'h1);
    rd(24'h000C18, 32'h0000_0001, "R8 bit24 in host byte0");

    // Bits 1 and 4 of register byte 0 land in host byte 3.
    access(1'b1, 24'h000000, 32'hFFFF_FFFF, 32'h0000_0012);
    rd(24'h000C18, 32'h1200_0001, "R8 byte0 to host byte3");

    // AND write clears host bit 0 (register bit 24), keeps the rest.
    wr(24'h000C18, 32'hFFFF_FFFE);
    rd(24'h000C18, 32'h1200_0000, "R3 and-clear");
    check("R5 irq dropped", {31'b0, irq_out}, 32'h0);

    // Write all ones keeps everything.
    wr(24'h000C18, 32'hFFFF_FFFF);
    rd(24'h000C18, 32'h1200_0000, "R3 ones keep");

    // Set and clear on the same edge: set wins on bit 4, bit 1 cleared.
    access(1'b1, 24'h000C18, 32'h0000_0000, 32'h0000_0010);
    rd(24'h000C18, 32'h1000_0000, "R4 set beats clear");

    // Summary registers.
    eth_sum = 2'b01;
    rd(24'h000C98, 32'h0100_0000, "R6 port0 summary");
    eth_sum = 2'b10;
    rd(24'h000C98, 32'h0200_0000, "R6 port1 summary");
    eth_sum = 2'b11;
    rd(24'h103A00, 32'h0300_0000, "R7 both ports");
    eth_sum = 2'b00;
    rd(24'h103A00, 32'h0000_0000, "R7 none");

    // Writes to read-only and unknown offsets change nothing.
    wr(24'h000C98, 32'h0000_0000);
    wr(24'h103A00, 32'h0000_0000);
    wr(24'h000100, 32'h0000_0000);
    rd(24'h000C18, 32'h1000_0000, "R6 cause after ro write");
    rd(24'h000C1C, 32'h0000_00FF, "R9 mask after stray write");

    // Mask bit 4 on: irq rises one edge later, mask cleared drops it.
    wr(24'h000C1C, 32'h1000_0000);
    check("R5 mask latency", {31'b0, irq_out}, 32'h0);
    idle(1);
    check("R5 mask enables", {31'b0, irq_out}, 32'h1);
    wr(24'h000C1C, 32'h0000_0000);
    idle(1);
    check("R5 mask disables", {31'b0, irq_out}, 32'h0);

    idle(2);
    check("R10 all reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule